// File: doc/BRIEF.md
# Lazy Transactional Conflict Tracker

This block sits beside a small fully-associative cache in a bus-snooping multiprocessor that runs hardware transactions with deferred versioning and deferred conflict checks. While a transaction runs, every access the core makes is looked up against the line tags. A read marks the line as part of the read footprint. A write marks it as part of the write footprint. A miss allocates a line as a read-only fill. The speculative data stays in the cache and is not published until commit.

At commit the block asks a central bus arbiter for ownership. After the grant it keeps the request raised and puts out the address of every line in its write footprint, one per cycle and in ascending line-slot order. Other cores use these addresses to drop their copies. Nothing is written back to memory here. The block also watches the commit broadcasts of other cores. If one of them names a line that the local transaction has read, and the local commit has not yet been granted, the local transaction aborts. An abort can also come from evicting a speculatively written line. Both endings clear all footprint marks. An abort also drops the written lines, so the transaction can restart from clean state.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset all lines are invalid. `arb_req_o`, `bcast_valid_o`, `commit_done_o`, `abort_o`, `acc_ack_o` and `acc_hit_o` are 0, and `abort_cause_o` is 2'b00.
- R2: While a transaction runs, an access is answered one cycle later with `acc_ack_o`=1. `acc_hit_o` is 1 if a valid line holds the address and 0 otherwise. A read miss allocates the line, so a second read of the same address hits.
- R3: A write marks its line, allocating it on a miss, as part of the write footprint. Lines that are only read are never broadcast at commit.
- R4: On a miss the lowest-numbered invalid slot is filled. When every slot is valid, the victim is chosen by a rotating pointer that starts at slot 0 and advances after each replacement. If the victim carries a write mark, the access is dropped with no ack, and the transaction aborts with `abort_cause_o`=2'b01.
- R5: `commit_req_o` during a transaction raises `arb_req_o` one cycle later. The request stays high through every broadcast until the cycle of `commit_done_o`, where it is low.
- R6: After `arb_gnt_i` is sampled, the write-footprint addresses appear on `bcast_addr_o` with `bcast_valid_o`, one per cycle and in ascending slot order, starting on the second cycle. A one-cycle `commit_done_o` pulse follows the last one. With W written lines, `commit_done_o` is seen W+2 cycles after the grant is driven.
- R7: A snooped address that matches a line in the read footprint, while running or while waiting for the grant, aborts the transaction one cycle later with `abort_cause_o`=2'b10. `arb_req_o` then drops.
- R8: Once the commit is granted, snooped addresses cause no abort and the commit completes.
- R9: An abort clears all marks and invalidates the written lines, while lines that were only read stay valid. A commit clears all marks and leaves the lines valid.
- R10: Accesses and commit requests outside a running transaction are ignored: there is no ack, no allocation and no bus request.
- R11: A snooped address invalidates a matching line without a write mark, including when idle. A matching line with a write mark is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin_i | input | 1 | Start a transaction (taken when idle) |
| acc_valid_i | input | 1 | Core access strobe |
| acc_write_i | input | 1 | Access is a write |
| acc_addr_i | input | AW | Line address of the access |
| commit_req_i | input | 1 | Request to commit the running transaction |
| arb_gnt_i | input | 1 | Grant from the central bus arbiter |
| snoop_valid_i | input | 1 | Another core's commit broadcast is valid |
| snoop_addr_i | input | AW | Snooped broadcast line address |
| acc_ack_o | output | 1 | Access accepted (one cycle after the access) |
| acc_hit_o | output | 1 | Accepted access hit a valid line |
| arb_req_o | output | 1 | Bus request, held through broadcast |
| bcast_valid_o | output | 1 | Broadcast address valid |
| bcast_addr_o | output | AW | Broadcast line address |
| commit_done_o | output | 1 | Commit finished pulse |
| abort_o | output | 1 | Abort pulse |
| abort_cause_o | output | 2 | 01 eviction, 10 conflict, 00 none; held until next begin |

## Verification
Access answers and aborts come out one cycle after the sampling edge, so the bench drives on the falling edge and samples the result on the next falling edge. The bus request is likewise checked one falling edge after the commit request. Broadcast addresses start two sampled edges after the grant is driven, and the done pulse follows W+2 edges after it. A cycle counter checks that exact spacing, while a scoreboard queue holds the expected sequence of acks, addresses, done pulses and aborts, in order. Because at most one of these events occurs per cycle, any unexpected or missing event shows up as a mismatch against the queue.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REQ   = 2'd2,
    ST_BCAST = 2'd3
  } tct_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_EVICT    = 2'b01,
    CAUSE_CONFLICT = 2'b10
  } tct_cause_e;
endpackage

// File: rtl/tct_tag_match.sv
module tct_tag_match #(
  parameter int NLINES = 8,
  parameter int AW     = 12
) (
  input  logic [NLINES-1:0]         valid_i,
  input  logic [NLINES-1:0][AW-1:0] tags_i,
  input  logic [AW-1:0]             key_i,
  output logic [NLINES-1:0]         hit_o
);
  for (genvar g = 0; g < NLINES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end
endmodule

// File: rtl/tct_first_set.sv
module tct_first_set #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
  import tct_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int AW     = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_begin_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          commit_req_i,
  input  logic          arb_gnt_i,
  input  logic          snoop_valid_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          acc_ack_o,
  output logic          acc_hit_o,
  output logic          arb_req_o,
  output logic          bcast_valid_o,
  output logic [AW-1:0] bcast_addr_o,
  output logic          commit_done_o,
  output logic          abort_o,
  output logic [1:0]    abort_cause_o
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  tct_state_e                state_q;
  logic [NLINES-1:0]         v_q, rd_q, wr_q, pend_q;
  logic [NLINES-1:0][AW-1:0] tag_q;
  logic [IW-1:0]             ptr_q, bc_idx_q;

  logic [NLINES-1:0] acc_hv, snp_hv, free_vec, snp_inval;
  logic              acc_found, free_found, pend_any;
  logic [IW-1:0]     acc_idx, free_idx, pend_idx, victim_idx, ptr_next;
  logic              victim_dirty, snp_conflict, conf_abort, evict_abort, do_abort;

  tct_tag_match #(.NLINES(NLINES), .AW(AW)) u_acc_match (
    .valid_i(v_q), .tags_i(tag_q), .key_i(acc_addr_i), .hit_o(acc_hv));
  tct_tag_match #(.NLINES(NLINES), .AW(AW)) u_snp_match (
    .valid_i(v_q), .tags_i(tag_q), .key_i(snoop_addr_i), .hit_o(snp_hv));

  assign free_vec = ~v_q;

  tct_first_set #(.N(NLINES)) u_acc_enc (
    .vec_i(acc_hv), .found_o(acc_found), .idx_o(acc_idx));
  tct_first_set #(.N(NLINES)) u_free_enc (
    .vec_i(free_vec), .found_o(free_found), .idx_o(free_idx));
  tct_first_set #(.N(NLINES)) u_pend_enc (
    .vec_i(pend_q), .found_o(pend_any), .idx_o(pend_idx));

  assign victim_idx   = free_found ? free_idx : ptr_q;
  assign victim_dirty = !free_found && wr_q[ptr_q];
  assign ptr_next     = (ptr_q == IW'(NLINES - 1)) ? '0 : ptr_q + 1'b1;
  assign snp_conflict = snoop_valid_i && |(snp_hv & rd_q);
  assign snp_inval    = snoop_valid_i ? (snp_hv & ~wr_q) : '0;
  assign conf_abort   = ((state_q == ST_RUN) || (state_q == ST_REQ)) && snp_conflict;
  assign evict_abort  = (state_q == ST_RUN) && !snp_conflict && acc_valid_i &&
                        !acc_found && victim_dirty;
  assign do_abort     = conf_abort || evict_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      v_q           <= '0;
      rd_q          <= '0;
      wr_q          <= '0;
      pend_q        <= '0;
      tag_q         <= '0;
      ptr_q         <= '0;
      bc_idx_q      <= '0;
      acc_ack_o     <= 1'b0;
      acc_hit_o     <= 1'b0;
      arb_req_o     <= 1'b0;
      bcast_valid_o <= 1'b0;
      bcast_addr_o  <= '0;
      commit_done_o <= 1'b0;
      abort_o       <= 1'b0;
      abort_cause_o <= CAUSE_NONE;
    end else begin
      acc_ack_o     <= 1'b0;
      acc_hit_o     <= 1'b0;
      bcast_valid_o <= 1'b0;
      commit_done_o <= 1'b0;
      abort_o       <= 1'b0;
      if (do_abort) begin
        // roll back: drop the speculative lines and every footprint mark
        v_q           <= v_q & ~wr_q & ~snp_inval;
        rd_q          <= '0;
        wr_q          <= '0;
        pend_q        <= '0;
        arb_req_o     <= 1'b0;
        abort_o       <= 1'b1;
        abort_cause_o <= conf_abort ? CAUSE_CONFLICT : CAUSE_EVICT;
        state_q       <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            v_q <= v_q & ~snp_inval;
            if (tx_begin_i) begin
              state_q       <= ST_RUN;
              abort_cause_o <= CAUSE_NONE;
            end
          end
          ST_RUN: begin
            v_q  <= v_q & ~snp_inval;
            rd_q <= rd_q & ~snp_inval;
            if (acc_valid_i) begin
              acc_ack_o <= 1'b1;
              if (acc_found) begin
                acc_hit_o <= 1'b1;
                if (acc_write_i) wr_q[acc_idx] <= 1'b1;
                else             rd_q[acc_idx] <= 1'b1;
              end else begin
                // read-only fill of the chosen slot, then mark it
                v_q[victim_idx]   <= 1'b1;
                tag_q[victim_idx] <= acc_addr_i;
                rd_q[victim_idx]  <= !acc_write_i;
                wr_q[victim_idx]  <= acc_write_i;
                if (!free_found) ptr_q <= ptr_next;
              end
            end
            if (commit_req_i) begin
              state_q   <= ST_REQ;
              arb_req_o <= 1'b1;
            end
          end
          ST_REQ: begin
            v_q  <= v_q & ~snp_inval;
            rd_q <= rd_q & ~snp_inval;
            if (arb_gnt_i) begin
              pend_q  <= wr_q & v_q;
              state_q <= ST_BCAST;
            end
          end
          ST_BCAST: begin
            if (pend_any) begin
              bcast_valid_o    <= 1'b1;
              bcast_addr_o     <= tag_q[pend_idx];
              bc_idx_q         <= pend_idx;
              pend_q[pend_idx] <= 1'b0;
            end else begin
              rd_q          <= '0;
              wr_q          <= '0;
              arb_req_o     <= 1'b0;
              commit_done_o <= 1'b1;
              state_q       <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: a broadcast address only appears while the bus is held
  assert_bcast_holds_bus_R5: assert property (@(posedge clk) disable iff (rst)
    bcast_valid_o |-> arb_req_o);

  // R5: the bus request only starts from a running transaction
  assert_req_from_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_req_o) |-> $past(state_q == ST_RUN));

  // R6: back-to-back broadcasts walk the slots upward
  assert_bcast_ascending_R6: assert property (@(posedge clk) disable iff (rst)
    (bcast_valid_o && $past(bcast_valid_o)) |-> (bc_idx_q > $past(bc_idx_q)));

  // R6: a transaction never both commits and aborts
  assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(commit_done_o && abort_o));

  // R7: every abort carries a reason
  assert_abort_cause_R7: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (abort_cause_o != CAUSE_NONE));

  // R8: a granted commit cannot be aborted
  assert_no_abort_granted_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BCAST) |=> !abort_o);

  // R9: after an abort no footprint mark survives
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> ((rd_q == '0) && (wr_q == '0)));
endmodule

// File: tb/tb_txn_conflict_tracker.sv
module tb_txn_conflict_tracker;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tx_begin_i = 1'b0, acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0, snoop_addr_i = '0;
  logic          commit_req_i = 1'b0, arb_gnt_i = 1'b0, snoop_valid_i = 1'b0;
  logic          acc_ack_o, acc_hit_o, arb_req_o, bcast_valid_o, commit_done_o, abort_o;
  logic [AW-1:0] bcast_addr_o;
  logic [1:0]    abort_cause_o;

  int checks = 0;
  int errors = 0;
  int      kq[$];
  int      vq[$];
  string   rq[$];

  always #4 clk = ~clk;  // 125 MHz

  txn_conflict_tracker #(.NLINES(8), .AW(AW)) dut (
    .clk(clk), .rst(rst), .tx_begin_i(tx_begin_i), .acc_valid_i(acc_valid_i),
    .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i), .commit_req_i(commit_req_i),
    .arb_gnt_i(arb_gnt_i), .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
    .acc_ack_o(acc_ack_o), .acc_hit_o(acc_hit_o), .arb_req_o(arb_req_o),
    .bcast_valid_o(bcast_valid_o), .bcast_addr_o(bcast_addr_o),
    .commit_done_o(commit_done_o), .abort_o(abort_o), .abort_cause_o(abort_cause_o));

  // event kinds: 0 ack (value = hit), 1 broadcast (value = address), 2 done, 3 abort (value = cause)
  task automatic push(input int k, input int v, input string r);
    kq.push_back(k); vq.push_back(v); rq.push_back(r);
  endtask

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: pops one expectation per produced event
  always @(negedge clk) begin
    if (!rst) begin
      int n, k, v;
      n = int'(acc_ack_o) + int'(bcast_valid_o) + int'(commit_done_o) + int'(abort_o);
      k = -1; v = 0;
      if (acc_ack_o)          begin k = 0; v = int'(acc_hit_o); end
      else if (bcast_valid_o) begin k = 1; v = int'(bcast_addr_o); end
      else if (commit_done_o) begin k = 2; v = 0; end
      else if (abort_o)       begin k = 3; v = int'(abort_cause_o); end
      if (n > 1) check(1'b0, "R6 single event per cycle", n, 1);
      if (k >= 0) begin
        if (kq.size() == 0) begin
          check(1'b0, "R10 unexpected event", k * 4096 + v, -1);
        end else begin
          int ek, ev;
          string er;
          ek = kq.pop_front(); ev = vq.pop_front(); er = rq.pop_front();
          check(ek == k && ev == v, er, k * 4096 + v, ek * 4096 + ev);
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic drain();
    for (int i = 0; i < 100 && kq.size() != 0; i++) @(negedge clk);
    check(kq.size() == 0, "scoreboard drained", kq.size(), 0);
    @(negedge clk);
  endtask

  task automatic begin_tx();
    tx_begin_i = 1'b1; @(negedge clk); tx_begin_i = 1'b0;
  endtask

  task automatic access(input bit w, input int a);
    acc_valid_i = 1'b1; acc_write_i = w; acc_addr_i = AW'(a);
    @(negedge clk);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  task automatic snoop(input int a);
    snoop_valid_i = 1'b1; snoop_addr_i = AW'(a);
    @(negedge clk);
    snoop_valid_i = 1'b0;
  endtask

  task automatic req_commit();
    commit_req_i = 1'b1; @(negedge clk); commit_req_i = 1'b0;
  endtask

  // grant the bus and time the done pulse; optionally snoop a read line during broadcast
  task automatic grant_commit(input int nwr, input bit snp, input int snp_a);
    int cnt;
    cnt = 0;
    arb_gnt_i = 1'b1;
    @(negedge clk); cnt++;
    if (snp) begin snoop_valid_i = 1'b1; snoop_addr_i = AW'(snp_a); end
    while (!commit_done_o && cnt < 50) begin
      @(negedge clk); cnt++;
      snoop_valid_i = 1'b0;
      if (!commit_done_o && cnt > 1)
        check(arb_req_o == 1'b1, "R5 request held during broadcast", arb_req_o, 1);
    end
    check(cnt == nwr + 2, "R6 done timing", cnt, nwr + 2);
    check(arb_req_o == 1'b0, "R5 request dropped at done", arb_req_o, 0);
    arb_gnt_i = 1'b0;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!acc_ack_o && !acc_hit_o && !arb_req_o && !bcast_valid_o && !commit_done_o && !abort_o,
          "R1 outputs idle in reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    check(abort_cause_o == 2'b00 && !arb_req_o, "R1 reset state", abort_cause_o, 0);

    // T1: read/write footprint, commit with snoop during broadcast
    begin_tx();
    push(0, 0, "R2 read miss");            access(0, 'h010);
    push(0, 1, "R2 read hit after fill");  access(0, 'h010);
    push(0, 0, "R3 write miss");           access(1, 'h020);
    push(0, 1, "R3 write hit");            access(1, 'h010);
    drain();
    req_commit();
    check(arb_req_o == 1'b1, "R5 request one cycle after commit", arb_req_o, 1);
    @(negedge clk);
    check(arb_req_o == 1'b1, "R5 request held awaiting grant", arb_req_o, 1);
    push(1, 'h010, "R6 broadcast slot0");
    push(1, 'h020, "R6 broadcast slot1");
    push(2, 0, "R8 commit completes despite snoop");
    grant_commit(2, 1'b1, 'h010);

    // T2: committed lines stay valid; write-only snoop no abort; read snoop aborts
    begin_tx();
    push(0, 1, "R9 committed line still valid"); access(0, 'h020);
    push(0, 0, "R3 write miss slot2");         access(1, 'h050);
    push(0, 0, "R3 write miss slot3");         access(1, 'h040);
    drain();
    snoop('h050);
    @(negedge clk);
    check(!abort_o, "R11 snoop on written line keeps running", abort_o, 0);
    push(3, 2, "R7 conflict abort");           snoop('h020);
    drain();

    // T3: written lines dropped, read lines kept; conflict while awaiting grant
    begin_tx();
    push(0, 1, "R9 read-only line survives abort"); access(0, 'h010);
    push(0, 0, "R9 written line dropped by abort"); access(0, 'h050);
    push(0, 0, "R9 written line dropped by abort"); access(0, 'h040);
    drain();
    req_commit();
    check(arb_req_o == 1'b1, "R5 request raised", arb_req_o, 1);
    push(3, 2, "R7 conflict abort before grant"); snoop('h010);
    check(arb_req_o == 1'b0, "R7 request dropped on abort", arb_req_o, 0);
    drain();

    // R10: idle access and commit request ignored
    access(0, 'h300);
    req_commit();
    check(arb_req_o == 1'b0, "R10 idle commit ignored", arb_req_o, 0);
    drain();

    // T4: fill all slots, rotating victim, eviction of a written line aborts
    begin_tx();
    push(0, 0, "R10 idle access did not allocate"); access(0, 'h300);
    for (int i = 1; i <= 5; i++) begin
      push(0, 0, "R4 fill free slot"); access(1, 'h100 + i);
    end
    push(0, 0, "R4 replace slot0"); access(0, 'h200);
    push(0, 0, "R4 replace slot1"); access(0, 'h201);
    push(0, 0, "R4 replace slot2"); access(0, 'h202);
    push(3, 1, "R4 eviction of written line aborts"); access(0, 'h203);
    drain();
    check(abort_cause_o == 2'b01, "R4 cause held", abort_cause_o, 1);

    // T5: broadcast order follows slots, read-only lines excluded
    begin_tx();
    check(abort_cause_o == 2'b00, "R1 cause cleared at begin", abort_cause_o, 0);
    push(0, 0, "R4 lowest free slot3"); access(1, 'h7F0);
    push(0, 0, "R4 lowest free slot4"); access(1, 'h001);
    push(0, 1, "R3 write hit slot0");   access(1, 'h200);
    push(0, 1, "R3 read hit slot1");    access(0, 'h201);
    drain();
    req_commit();
    push(1, 'h200, "R6 ascending slot0");
    push(1, 'h7F0, "R6 ascending slot3");
    push(1, 'h001, "R6 ascending slot4");
    push(2, 0, "R6 done after last");
    grant_commit(3, 1'b0, 0);

    // T6: empty write footprint commits right after grant
    begin_tx();
    req_commit();
    push(2, 0, "R6 empty commit");
    grant_commit(0, 1'b0, 0);

    // R11: idle snoop drops a clean line, other lines untouched
    snoop('h201);
    begin_tx();
    push(0, 0, "R11 snooped line invalidated"); access(0, 'h201);
    push(0, 1, "R11 other line kept");          access(0, 'h202);
    drain();
    req_commit();
    push(2, 0, "R3 read-only commit has no broadcast");
    grant_commit(0, 1'b0, 0);

    finish_run();
  end
endmodule